// File: doc/BRIEF.md
# Two-Group Interrupt Routing Controller

The block gathers level-sensitive interrupt requests from two groups of sixteen sources each. Every source passes through a two-stage synchroniser into a per-group pending word, is gated by a per-group enable mask, and is then steered to one of five processor interrupt lines. Most steering choices are programmable through 3-bit line-select fields. Only some source pins have such a field. The fields are packed into four 16-bit select words. Each processor line is the registered OR of every enabled, pending source steered to it.

Software reaches all state through a 16-bit register port. A bank bit selects one of two register banks, and a 5-bit byte offset selects the halfword inside the bank. A write takes effect on the clock edge where the write strobe is sampled. Read data for the presented bank and offset appears after the next clock edge.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset both enable masks read 0 and all five lines are low. Select word at bank 0 offset 0x04 reads 0x0040 (group-A pin 2 to line 1). Select word at bank 0 offset 0x1C reads 0x0002 (group-B pin 0 to line 2). The select words at 0x06 and 0x1E read 0.
- R2: Each line is high exactly when some source steered to it is both pending and enabled. The line changes one clock after the mask or select state changes.
- R3: A source whose mask bit is 0 drives no line, whatever its pending state.
- R4: Group-A select fields are placed as follows. In bank 0 offset 0x04, pins 0, 1, 2, 3 and 8 use bits [2:0], [5:3], [8:6], [11:9] and [14:12]. In bank 0 offset 0x06, pins 9, 11 and 12 use bits [2:0], [8:6] and [11:9]. A field value n in 0..4 selects line n.
- R5: Group-B select fields are placed as follows. In bank 0 offset 0x1C, pins 0, 1, 3, 4 and 5 use bits [2:0], [5:3], [8:6], [11:9] and [14:12]. In bank 0 offset 0x1E, pins 6 to 10 use the same five bit positions in that order.
- R6: A select field holding 5, 6 or 7 steers its pin to line 0. The field reads back the value written.
- R7: Pins without a select field have fixed steering. Group-B pin 2 always goes to line 3, and every other such pin goes to line 0.
- R8: Select-word bits that hold no field read 0. This means bit 15 of every select word, and bits [5:3] and [14:12] of the word at 0x06.
- R9: The pending words (bank 0 and bank 1, offset 0x00) read the source inputs after two synchroniser clocks. Writes to them have no effect. A source change reaches a line three clocks after it is sampled.
- R10: The group-A mask is at bank 0 offset 0x0C and the group-B mask is at bank 1 offset 0x06. Read data is valid one clock after the bank and offset are presented.
- R11: Any other bank/offset pair reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 16 | Group-A level interrupt sources (asynchronous) |
| src_b | input | 16 | Group-B level interrupt sources (asynchronous) |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_bank | input | 1 | Register bank select (0 or 1) |
| bus_addr | input | 5 | Byte offset within the bank |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the presented bank/offset |
| irq_line | output | 5 | Registered processor interrupt lines 0 to 4 |

## Verification
The assertions assume that every source, once synchronised, maps to some line 0..4. On that basis any enabled pending source must raise at least one line on the following clock, and any raised line needs such a source. They also assume that bus_wr, bus_bank, bus_addr and bus_wdata are stable at the clock edge. The bench meets this by changing every port input only on falling edges. It holds source patterns steady long enough for the synchroniser to settle before sampling, except in the tests that measure the latency itself.

// File: rtl/irq_route_pkg.sv
// Shared constants and the pin-to-field map for the interrupt routing controller.
// Assumes two groups of 16 sources, 3-bit select fields, four select words.
package irq_route_pkg;

    localparam int GROUPS   = 2;
    localparam int SRC_W    = 16;
    localparam int FIELD_W  = 3;
    localparam int SEL_REGS = 4;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;

    // Byte offsets inside the banks
    localparam logic [ADDR_W-1:0] OFS_PEND    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_SEL0    = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_SEL1    = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_MASK_A  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_SEL2    = 5'h1C;
    localparam logic [ADDR_W-1:0] OFS_SEL3    = 5'h1E;
    localparam logic [ADDR_W-1:0] OFS_MASK_B  = 5'h06;

    // Bits of each select word that hold a field, and reset contents
    localparam logic [DATA_W-1:0] SEL_IMPL [SEL_REGS] = '{16'h7FFF, 16'h0FC7, 16'h7FFF, 16'h7FFF};
    localparam logic [DATA_W-1:0] SEL_RST  [SEL_REGS] = '{16'h0040, 16'h0000, 16'h0002, 16'h0000};

    typedef struct packed {
        logic       has;
        logic [1:0] word;
        logic [3:0] lsb;
    } field_loc_t;

    // Location of the select field of a pin, or has=0 when the pin has none
    function automatic field_loc_t field_of(input int grp, input int pin);
        field_loc_t f;
        f = '{has: 1'b0, word: 2'd0, lsb: 4'd0};
        if (grp == 0) begin
            case (pin)
                0, 1, 2, 3: f = '{has: 1'b1, word: 2'd0, lsb: 4'(pin * 3)};
                8:          f = '{has: 1'b1, word: 2'd0, lsb: 4'd12};
                9:          f = '{has: 1'b1, word: 2'd1, lsb: 4'd0};
                11:         f = '{has: 1'b1, word: 2'd1, lsb: 4'd6};
                12:         f = '{has: 1'b1, word: 2'd1, lsb: 4'd9};
                default:    f.has = 1'b0;
            endcase
        end else begin
            case (pin)
                0, 1:             f = '{has: 1'b1, word: 2'd2, lsb: 4'(pin * 3)};
                3, 4, 5:          f = '{has: 1'b1, word: 2'd2, lsb: 4'((pin - 1) * 3)};
                6, 7, 8, 9, 10:   f = '{has: 1'b1, word: 2'd3, lsb: 4'((pin - 6) * 3)};
                default:          f.has = 1'b0;
            endcase
        end
        return f;
    endfunction

    // Line used by a pin that has no select field
    function automatic logic [FIELD_W-1:0] fixed_line(input int grp, input int pin);
        return (grp == 1 && pin == 2) ? 3'd3 : 3'd0;
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchroniser for a vector of level inputs.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module irq_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_regfile.sv
// Register bank: enable masks, select words and the registered read path.
// Assumes pending words come from the synchronisers and are read-only here.
module irq_regfile
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_bank,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_W-1:0]  pend_a,
    input  logic [SRC_W-1:0]  pend_b,
    output logic [SRC_W-1:0]  mask_a,
    output logic [SRC_W-1:0]  mask_b,
    output logic [DATA_W-1:0] sel_word [SEL_REGS]
);
    localparam logic [ADDR_W-1:0] SEL_OFS [SEL_REGS] = '{OFS_SEL0, OFS_SEL1, OFS_SEL2, OFS_SEL3};

    logic wr_a, wr_b;
    assign wr_a = bus_wr && !bus_bank;
    assign wr_b = bus_wr &&  bus_bank;

    // Enable masks: cleared by reset, written whole
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_a <= '0;
            mask_b <= '0;
        end else begin
            if (wr_a && bus_addr == OFS_MASK_A) mask_a <= bus_wdata;
            if (wr_b && bus_addr == OFS_MASK_B) mask_b <= bus_wdata;
        end
    end

    // Select words, one per generate slice, keeping only implemented bits
    for (genvar r = 0; r < SEL_REGS; r++) begin : g_sel
        always_ff @(posedge clk) begin
            if (!rst_n)                         sel_word[r] <= SEL_RST[r];
            else if (wr_a && bus_addr == SEL_OFS[r]) sel_word[r] <= bus_wdata & SEL_IMPL[r];
        end
    end

    // Read mux, registered so data follows the address by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (!bus_bank) begin
            case (bus_addr)
                OFS_PEND:   bus_rdata <= pend_a;
                OFS_MASK_A: bus_rdata <= mask_a;
                OFS_SEL0:   bus_rdata <= sel_word[0];
                OFS_SEL1:   bus_rdata <= sel_word[1];
                OFS_SEL2:   bus_rdata <= sel_word[2];
                OFS_SEL3:   bus_rdata <= sel_word[3];
                default:    bus_rdata <= '0;
            endcase
        end else begin
            case (bus_addr)
                OFS_PEND:   bus_rdata <= pend_b;
                OFS_MASK_B: bus_rdata <= mask_b;
                default:    bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_router.sv
// Steers each enabled pending source to its line and registers the OR per line.
// Assumes select fields above the last line number mean line 0.
module irq_router
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_W-1:0]     pend_a,
    input  logic [SRC_W-1:0]     pend_b,
    input  logic [SRC_W-1:0]     mask_a,
    input  logic [SRC_W-1:0]     mask_b,
    input  logic [DATA_W-1:0]    sel_word [SEL_REGS],
    output logic [NUM_LINES-1:0] irq_line
);
    localparam logic [FIELD_W-1:0] MAX_LINE = FIELD_W'(NUM_LINES - 1);

    logic [SRC_W-1:0]   en [GROUPS];
    logic [FIELD_W-1:0] sel [GROUPS][SRC_W];
    logic [NUM_LINES-1:0] nxt;

    assign en[0] = pend_a & mask_a;
    assign en[1] = pend_b & mask_b;

    // Per-pin effective line: field if present, else fixed; illegal values fold to 0
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar p = 0; p < SRC_W; p++) begin : g_pin
            localparam field_loc_t LOC = field_of(g, p);
            logic [FIELD_W-1:0] raw;
            if (LOC.has) begin : g_field
                assign raw = sel_word[LOC.word][LOC.lsb +: FIELD_W];
            end else begin : g_fixed
                assign raw = fixed_line(g, p);
            end
            assign sel[g][p] = (raw > MAX_LINE) ? '0 : raw;
        end
    end

    // OR network: a line is set by any enabled source steered to it
    always_comb begin
        nxt = '0;
        for (int l = 0; l < NUM_LINES; l++)
            for (int g = 0; g < GROUPS; g++)
                for (int p = 0; p < SRC_W; p++)
                    if (en[g][p] && sel[g][p] == FIELD_W'(l)) nxt[l] = 1'b1;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) irq_line <= '0;
        else        irq_line <= nxt;
    end
endmodule

// File: rtl/irq_route_ctrl.sv
// Top of the two-group interrupt routing controller.
// Assumes asynchronous level sources and a bus driven synchronously to clk.
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_LINES   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          src_a,
    input  logic [15:0]          src_b,
    input  logic                 bus_wr,
    input  logic                 bus_bank,
    input  logic [4:0]           bus_addr,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_line
);
    logic [SRC_W-1:0]  pend_a, pend_b, mask_a, mask_b;
    logic [DATA_W-1:0] sel_word [SEL_REGS];

    irq_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .d(src_a), .q(pend_a));
    irq_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .d(src_b), .q(pend_b));

    irq_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_bank(bus_bank), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_a(pend_a), .pend_b(pend_b),
        .mask_a(mask_a), .mask_b(mask_b), .sel_word(sel_word));

    irq_router #(.NUM_LINES(NUM_LINES)) u_route (
        .clk(clk), .rst_n(rst_n),
        .pend_a(pend_a), .pend_b(pend_b),
        .mask_a(mask_a), .mask_b(mask_b),
        .sel_word(sel_word), .irq_line(irq_line));
endmodule

// File: rtl/irq_route_chk.sv
// Property checker for the routing controller, bound into the top.
// Assumes bus inputs are stable at the clock edge.
module irq_route_chk #(
    parameter int NUM_LINES = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic                 bus_bank,
    input logic [4:0]           bus_addr,
    input logic [15:0]          bus_wdata,
    input logic [15:0]          pend_a,
    input logic [15:0]          pend_b,
    input logic [15:0]          mask_a,
    input logic [15:0]          mask_b,
    input logic [NUM_LINES-1:0] irq_line
);
    // R3: a raised line needs an enabled pending source one clock earlier
    a_r3_no_line_without_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line != '0) |-> $past(((pend_a & mask_a) != 16'h0) || ((pend_b & mask_b) != 16'h0)));

    // R2: an enabled pending source raises some line on the next clock
    a_r2_source_reaches_line: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend_a & mask_a) != 16'h0) || ((pend_b & mask_b) != 16'h0)) |=> (irq_line != '0));

    // R10: group-A mask takes the written word
    a_r10_mask_a_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_bank && bus_addr == 5'h0C) |=> (mask_a == $past(bus_wdata)));

    // R10: group-B mask takes the written word
    a_r10_mask_b_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_bank && bus_addr == 5'h06) |=> (mask_b == $past(bus_wdata)));

    // R11: a write to an undefined offset leaves both masks alone
    a_r11_undef_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'h02) |=> ($stable(mask_a) && $stable(mask_b)));
endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bank(bus_bank),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pend_a(pend_a), .pend_b(pend_b), .mask_a(mask_a), .mask_b(mask_b),
    .irq_line(irq_line));

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_a = '0, src_b = '0;
    logic        bus_wr = 1'b0, bus_bank = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [4:0]  irq_line;

    int checks = 0;
    int errors = 0;

    irq_route_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .bus_wr(bus_wr), .bus_bank(bus_bank), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: mask_a, mask_b, src_a, src_b, expected lines (reset steering)
    localparam int NV = 8;
    localparam logic [68:0] VEC [NV] = '{
        {16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 5'b00000},
        {16'hFFFF, 16'hFFFF, 16'h0004, 16'h0000, 5'b00010},
        {16'hFFFF, 16'hFFFF, 16'h0000, 16'h0001, 5'b00100},
        {16'hFFFF, 16'hFFFF, 16'h0000, 16'h0004, 5'b01000},
        {16'hFFFF, 16'hFFFF, 16'h0010, 16'h0000, 5'b00001},
        {16'h0000, 16'hFFFF, 16'hFFFF, 16'h0005, 5'b01100},
        {16'hFFFB, 16'h0000, 16'h0004, 16'hFFFF, 5'b00000},
        {16'hFFFF, 16'hFFFA, 16'h0000, 16'h0007, 5'b00001}
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic bank, input logic [4:0] addr, input logic [15:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_bank = bank; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic bank, input logic [4:0] addr, output logic [15:0] data);
        @(negedge clk);
        bus_bank = bank; bus_addr = addr;
        @(negedge clk);
        data = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 lines", {11'd0, irq_line}, 16'h0000);
        rd(1'b0, 5'h0C, d); check("R1 mask A", d, 16'h0000);
        rd(1'b1, 5'h06, d); check("R1 mask B", d, 16'h0000);
        rd(1'b0, 5'h04, d); check("R1 sel 0x04", d, 16'h0040);
        rd(1'b0, 5'h1C, d); check("R1 sel 0x1C", d, 16'h0002);
        rd(1'b0, 5'h06, d); check("R1 sel 0x06", d, 16'h0000);

        // R2 R3 R7: table of default-steering vectors
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, 5'h0C, VEC[i][68:53]);
            wr(1'b1, 5'h06, VEC[i][52:37]);
            src_a = VEC[i][36:21];
            src_b = VEC[i][20:5];
            settle();
            check($sformatf("R2/R3/R7 vector %0d", i), {11'd0, irq_line}, {11'd0, VEC[i][4:0]});
        end

        // R4: group-A pin 8 field at [14:12] set to 4
        wr(1'b0, 5'h0C, 16'hFFFF); wr(1'b1, 5'h06, 16'hFFFF);
        wr(1'b0, 5'h04, 16'h4040);
        src_a = 16'h0100; src_b = 16'h0000; settle();
        check("R4 pin8 to line4", {11'd0, irq_line}, 16'h0010);
        rd(1'b0, 5'h04, d); check("R4 readback", d, 16'h4040);
        // R4: group-A pin 12 in word 0x06 bits [11:9] set to 2
        wr(1'b0, 5'h06, 16'h0400);
        src_a = 16'h1000; settle();
        check("R4 pin12 to line2", {11'd0, irq_line}, 16'h0004);

        // R6: value 6 folds to line 0 and reads back as written
        wr(1'b0, 5'h04, 16'h6000);
        src_a = 16'h0100; settle();
        check("R6 illegal select", {11'd0, irq_line}, 16'h0001);
        rd(1'b0, 5'h04, d); check("R6 readback", d, 16'h6000);

        // R5: group-B pin 10 at word 0x1E [14:12] = 3, pin 0 at 0x1C [2:0] = 4
        src_a = 16'h0000;
        wr(1'b0, 5'h1E, 16'h3000);
        src_b = 16'h0400; settle();
        check("R5 B pin10 to line3", {11'd0, irq_line}, 16'h0008);
        wr(1'b0, 5'h1C, 16'h0004);
        src_b = 16'h0001; settle();
        check("R5 B pin0 to line4", {11'd0, irq_line}, 16'h0010);

        // R8: unimplemented bits read 0
        wr(1'b0, 5'h06, 16'hFFFF);
        rd(1'b0, 5'h06, d); check("R8 sel 0x06", d, 16'h0FC7);
        wr(1'b0, 5'h1E, 16'hFFFF);
        rd(1'b0, 5'h1E, d); check("R8 sel 0x1E", d, 16'h7FFF);

        // R9: pending reflects sources; writes to it do nothing
        src_a = 16'h00F0; src_b = 16'hA005; settle();
        wr(1'b0, 5'h00, 16'h1234);
        rd(1'b0, 5'h00, d); check("R9 pending A", d, 16'h00F0);
        wr(1'b1, 5'h00, 16'h5A5A);
        rd(1'b1, 5'h00, d); check("R9 pending B", d, 16'hA005);

        // R11: undefined offsets read 0, writes leave registers alone
        wr(1'b0, 5'h0C, 16'h1357);
        wr(1'b0, 5'h02, 16'hFFFF);
        rd(1'b0, 5'h02, d); check("R11 undefined read", d, 16'h0000);
        wr(1'b1, 5'h0C, 16'hFFFF);
        rd(1'b1, 5'h0C, d); check("R11 bank1 undefined read", d, 16'h0000);
        rd(1'b0, 5'h0C, d); check("R11 mask A untouched", d, 16'h1357);

        // R10: read data valid one clock after address
        @(negedge clk);
        bus_bank = 1'b1; bus_addr = 5'h06;
        @(negedge clk);
        check("R10 mask B read latency", bus_rdata, 16'hFFFF);

        // R2: line follows a mask write by one clock
        src_b = 16'h0000; src_a = 16'h0010;
        wr(1'b1, 5'h06, 16'h0000);
        wr(1'b0, 5'h0C, 16'h0000); settle();
        wr(1'b0, 5'h0C, 16'h0010);
        check("R2 before output edge", {11'd0, irq_line}, 16'h0000);
        @(negedge clk);
        check("R2 after output edge", {11'd0, irq_line}, 16'h0001);

        // R9: source to line takes three clocks
        src_a = 16'h0000; settle();
        src_a = 16'h0010;
        repeat (2) @(negedge clk);
        check("R9 two clocks after source", {11'd0, irq_line}, 16'h0000);
        @(negedge clk);
        check("R9 three clocks after source", {11'd0, irq_line}, 16'h0001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule